// File: doc/BRIEF.md
# Dual Prescaled Down-Counter Timer

Two 8-bit down-counting timers share one small register bus. Each has its own 6-bit prescaler. Software writes a reload value, a prescaler divisor and a count mode, then sets a load bit and an enable bit. Each timer counts prescaled ticks down to terminal count. It then either stops or reloads and keeps running. Each terminal count toggles a per-timer output flip-flop.

A single external timing input serves timer 1. It can clock timer 1 directly, gate it, or start it with a falling edge, and the trigger can be made retriggerable or not. A single timer output pin shows one of three things: a timer's toggle, a divided system clock, or a constant low. Outside the clock-input role, timer 0 and timer 1 both take their prescaler ticks from an internal timebase that fires once every four system clocks.

The bus is synchronous. A write takes effect at the clock edge where the write strobe is high. A read is combinational from the address.

Top module: `dual_timer`

## Requirements
- R1: Reset clears all state. After reset, the mode register (address 0) and both counters (addresses 1 and 2) read 0x00, and the timer output is low.
- R2: Writing address 1 (timer 0) or address 2 (timer 1) stores that timer's reload value, and a read of the same address returns the live count. In the mode register, bit 1 is enable 0, bit 3 is enable 1, bits 5:4 select the input role and bits 7:6 select the output. Writing 1 to bit 0 or bit 2 copies the reload value and the prescaler divisor into timer 0 or timer 1. The load bits always read back as 0.
- R3: The prescaler registers are at address 3 (timer 0) and address 4 (timer 1). Bits 7:2 hold the divisor N, and the prescaler emits one count step every N ticks, or every 64 ticks when N is 0. Bit 0 is the count mode.
- R4: The internal timebase produces one prescaler tick every four system clocks.
- R5: A counter decrements by one on each prescaler step, and only while its enable bit is 1. Terminal count is the step from 1 to 0. A reload value of 0 gives 256 steps.
- R6: When the count mode is 0 (single pass), terminal count leaves the counter at 0 and clears that timer's enable bit.
- R7: When the count mode is 1, terminal count reloads the reload value and the timer keeps counting.
- R8: The output field works as follows. 00 holds the pin low. 01 shows timer 0's toggle flip-flop and 10 shows timer 1's; each flips once per terminal count. 11 shows the internal clock, which is low for two system clocks and then high for two.
- R9: Bit 1 of the address-4 register is timer 1's clock source. A 1 selects the internal timebase. A 0 makes each rising edge of the input (after a two-flop synchronizer) one prescaler tick.
- R10: With input role 01 (gate), timer 1 steps only while the synchronized input is high.
- R11: With input role 10, a falling edge of the synchronized input loads timer 1 and sets enable 1, but only if timer 1 is not already enabled. Edges that arrive while it is enabled change nothing.
- R12: With input role 11, every falling edge reloads timer 1 and sets enable 1, even while timer 1 is running.
- R13: Reads of addresses 3 and 4 return all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| tin | input | 1 | External timing input, asynchronous |
| tout | output | 1 | Selected timer output |

## Verification
Timer 0 is run in three ways:
- modulo mode with a small divisor, which tells reload apart from stopping;
- single pass with divisor 0, which separates 64 from 0 ticks;
- single pass with a reload value of 0, which separates 256 steps from none.

Timer 1 is driven through the external input in each role:
- a toggling clock, which shows edge counting against the internal timebase;
- a high–low–high level in gate mode, which shows counting pausing and resuming;
- falling-edge bursts during and after a run, which tell the non-retriggerable mode apart from the retriggerable one, since only the latter restarts mid-count.

A halt by clearing the enable bit, and the internal clock on the pin, complete the set.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int AW  = 3;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    IN_CLOCK     = 2'd0,
    IN_GATE      = 2'd1,
    IN_TRIG_ONCE = 2'd2,
    IN_TRIG_RE   = 2'd3
  } in_mode_e;

  typedef enum logic [1:0] {
    OUT_LOW = 2'd0,
    OUT_T0  = 2'd1,
    OUT_T1  = 2'd2,
    OUT_CLK = 2'd3
  } out_mode_e;

  localparam logic [AW-1:0] ADDR_MODE = 3'd0;
  localparam logic [AW-1:0] ADDR_CNT0 = 3'd1;
  localparam logic [AW-1:0] ADDR_CNT1 = 3'd2;
  localparam logic [AW-1:0] ADDR_PRE0 = 3'd3;
  localparam logic [AW-1:0] ADDR_PRE1 = 3'd4;
endpackage

// File: rtl/dtmr_insync.sv
module dtmr_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~last_q;
  assign fall  = ~level & last_q;
endmodule

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] modulo,
  input  logic         step,
  output logic         pulse
);
  logic [W-1:0] cnt_q;

  // A value of 0 wraps through 2**W-1 and so spans 2**W ticks.
  function automatic logic [W-1:0] pre_next(logic [W-1:0] c, logic [W-1:0] m);
    return (c == W'(1)) ? m : c - W'(1);
  endfunction

  assign pulse = step && !load && (cnt_q == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= modulo;
    else if (step) cnt_q <= pre_next(cnt_q, modulo);
  end
endmodule

// File: rtl/dtmr_downcount.sv
module dtmr_downcount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] init,
  input  logic         step,
  input  logic         reload,
  output logic [W-1:0] count,
  output logic         tc
);
  logic [W-1:0] cnt_q;

  function automatic logic [W-1:0] cnt_next(logic [W-1:0] c, logic [W-1:0] iv, logic rl);
    if (c == W'(1)) return rl ? iv : '0;
    return c - W'(1);
  endfunction

  assign tc    = step && !load && (cnt_q == W'(1));
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= init;
    else if (step) cnt_q <= cnt_next(cnt_q, init, reload);
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtmr_pkg::*;
#(
  parameter int DW      = 8,
  parameter int PRE_W   = 6,
  parameter int DIV_LOG = 2,
  parameter int SYNC_N  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tin,
  output logic          tout
);
  localparam int PRE_LSB = DW - PRE_W;

  logic [DIV_LOG-1:0]         div_q;
  logic                       tick_int;
  logic [NCH-1:0]             en_q, rl_q, load_ch, src_tick, pre_step, cstep, eoc, tog_q;
  logic [NCH-1:0][DW-1:0]     init_q, cnt_q;
  logic [NCH-1:0][PRE_W-1:0]  pmod_q;
  in_mode_e                   in_mode_q;
  out_mode_e                  out_mode_q;
  logic                       t1_int_q;
  logic                       tin_lvl, tin_rise, tin_fall;
  logic                       trig_fire, gate_ok, wr_mode;

  function automatic logic trig_accept(in_mode_e m, logic edge_f, logic running);
    case (m)
      IN_TRIG_ONCE: return edge_f && !running;
      IN_TRIG_RE:   return edge_f;
      default:      return 1'b0;
    endcase
  endfunction

  dtmr_insync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(tin),
    .level(tin_lvl), .rise(tin_rise), .fall(tin_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end
  assign tick_int = &div_q;

  assign wr_mode     = bus_wr && (bus_addr == ADDR_MODE);
  assign trig_fire   = trig_accept(in_mode_q, tin_fall, en_q[1]);
  assign gate_ok     = (in_mode_q != IN_GATE) || tin_lvl;
  assign load_ch[0]  = wr_mode && bus_wdata[0];
  assign load_ch[1]  = (wr_mode && bus_wdata[2]) || trig_fire;
  assign src_tick[0] = tick_int;
  assign src_tick[1] = t1_int_q ? tick_int : tin_rise;
  assign pre_step[0] = en_q[0] && src_tick[0];
  assign pre_step[1] = en_q[1] && src_tick[1] && gate_ok;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dtmr_prescaler #(.W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .load(load_ch[g]), .modulo(pmod_q[g]),
      .step(pre_step[g]), .pulse(cstep[g])
    );
    dtmr_downcount #(.W(DW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load_ch[g]), .init(init_q[g]),
      .step(cstep[g]), .reload(rl_q[g]), .count(cnt_q[g]), .tc(eoc[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= '0;
    else        tog_q <= tog_q ^ eoc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      rl_q       <= '0;
      init_q     <= '0;
      pmod_q     <= '0;
      in_mode_q  <= IN_CLOCK;
      out_mode_q <= OUT_LOW;
      t1_int_q   <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++)
        if (eoc[i] && !rl_q[i]) en_q[i] <= 1'b0;
      if (trig_fire) en_q[1] <= 1'b1;
      if (bus_wr) begin
        case (bus_addr)
          ADDR_MODE: begin
            en_q       <= {bus_wdata[3], bus_wdata[1]};
            in_mode_q  <= in_mode_e'(bus_wdata[5:4]);
            out_mode_q <= out_mode_e'(bus_wdata[7:6]);
          end
          ADDR_CNT0: init_q[0] <= bus_wdata;
          ADDR_CNT1: init_q[1] <= bus_wdata;
          ADDR_PRE0: begin
            pmod_q[0] <= bus_wdata[DW-1:PRE_LSB];
            rl_q[0]   <= bus_wdata[0];
          end
          ADDR_PRE1: begin
            pmod_q[1] <= bus_wdata[DW-1:PRE_LSB];
            rl_q[1]   <= bus_wdata[0];
            t1_int_q  <= bus_wdata[1];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_MODE: begin
        bus_rdata[7:6] = out_mode_q;
        bus_rdata[5:4] = in_mode_q;
        bus_rdata[3]   = en_q[1];
        bus_rdata[1]   = en_q[0];
      end
      ADDR_CNT0: bus_rdata = cnt_q[0];
      ADDR_CNT1: bus_rdata = cnt_q[1];
      ADDR_PRE0, ADDR_PRE1: bus_rdata = '1;
      default: ;
    endcase
  end

  always_comb begin
    case (out_mode_q)
      OUT_T0:  tout = tog_q[0];
      OUT_T1:  tout = tog_q[1];
      OUT_CLK: tout = div_q[DIV_LOG-1];
      default: tout = 1'b0;
    endcase
  end
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [2:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          tin_lvl,
  input logic          tin_fall,
  input logic [1:0]    in_mode,
  input logic [1:0]    en,
  input logic [1:0]    rl,
  input logic [1:0]    eoc,
  input logic [1:0]    cstep,
  input logic [1:0]    load_ch,
  input logic [1:0]    tog,
  input logic [DW-1:0] cnt0,
  input logic [DW-1:0] cnt1,
  input logic [DW-1:0] init0,
  input logic [DW-1:0] init1
);
  logic mode_wr;
  assign mode_wr = bus_wr && (bus_addr == 3'd0);

  // R6 R7
  eoc_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc[0] |=> cnt0 == ($past(rl[0]) ? $past(init0) : {DW{1'b0}}));

  // R6
  single_pass_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc[0] && !rl[0] && !mode_wr |=> !en[0]);

  // R2
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && bus_wdata[0] |=> cnt0 == $past(init0));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cstep[0] && !load_ch[0] |=> $stable(cnt0));

  // R8
  toggle_only_on_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc[1] |=> $stable(tog[1]));

  // R10
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_mode == 2'd1 && !tin_lvl && !load_ch[1] |=> $stable(cnt1));

  // R11
  no_retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_mode == 2'd2 && tin_fall && en[1] && !mode_wr && !cstep[1] |=> $stable(cnt1));

  // R12
  retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_mode == 2'd3 && tin_fall && !mode_wr |=> cnt1 == $past(init1) && en[1]);
endmodule

bind dual_timer dtmr_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tin_lvl(tin_lvl), .tin_fall(tin_fall),
  .in_mode(in_mode_q), .en(en_q), .rl(rl_q), .eoc(eoc), .cstep(cstep),
  .load_ch(load_ch), .tog(tog_q), .cnt0(cnt_q[0]), .cnt1(cnt_q[1]),
  .init0(init_q[0]), .init1(init_q[1])
);

// File: tb/tb_dual_timer.sv
module tb_dual_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       tin = 1'b0;
  logic       tout;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    run_cmp = 1'b0;

  always #10 clk = ~clk;

  dual_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tin(tin), .tout(tout)
  );

  // behavioural reference state
  int m_div, m_s1, m_s2, m_s3, m_in, m_out, m_isrc;
  int m_en[2], m_cnt[2], m_left[2], m_init[2], m_pmod[2], m_rl[2], m_tog[2];

  function automatic int period(int n);
    return (n == 0) ? 64 : n;
  endfunction

  always @(posedge clk) begin
    int tick, rise, fall, fire, mw;
    int n_cnt[2], n_left[2], n_en[2], tc[2];
    if (!rst_n) begin
      m_div = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_in = 0; m_out = 0; m_isrc = 0;
      for (int i = 0; i < 2; i++) begin
        m_en[i] = 0; m_cnt[i] = 0; m_left[i] = 64; m_init[i] = 0;
        m_pmod[i] = 0; m_rl[i] = 0; m_tog[i] = 0;
      end
    end else begin
      tick = (m_div == 3);
      rise = (m_s2 == 1 && m_s3 == 0);
      fall = (m_s2 == 0 && m_s3 == 1);
      mw   = (bus_wr && bus_addr == 3'd0);
      fire = fall && (m_in == 3 || (m_in == 2 && m_en[1] == 0));
      for (int i = 0; i < 2; i++) begin
        int ld, srct, stp;
        ld   = (mw && bus_wdata[2*i]) || (i == 1 && fire);
        srct = (i == 0 || m_isrc == 1) ? tick : rise;
        stp  = m_en[i] && srct && (i == 0 || m_in != 1 || m_s2 == 1);
        tc[i] = 0; n_cnt[i] = m_cnt[i]; n_left[i] = m_left[i]; n_en[i] = m_en[i];
        if (ld) begin
          n_left[i] = period(m_pmod[i]);
          n_cnt[i]  = m_init[i];
        end else if (stp) begin
          n_left[i] = m_left[i] - 1;
          if (n_left[i] == 0) begin
            n_left[i] = period(m_pmod[i]);
            if (m_cnt[i] == 1) begin
              tc[i] = 1;
              n_cnt[i] = m_rl[i] ? m_init[i] : 0;
            end else n_cnt[i] = (m_cnt[i] + 255) % 256;
          end
        end
        if (tc[i] && !m_rl[i]) n_en[i] = 0;
      end
      if (fire) n_en[1] = 1;
      if (mw) begin
        n_en[0] = bus_wdata[1]; n_en[1] = bus_wdata[3];
        m_in = bus_wdata[5:4]; m_out = bus_wdata[7:6];
      end
      if (bus_wr) begin
        case (bus_addr)
          3'd1: m_init[0] = bus_wdata;
          3'd2: m_init[1] = bus_wdata;
          3'd3: begin m_pmod[0] = bus_wdata[7:2]; m_rl[0] = bus_wdata[0]; end
          3'd4: begin m_pmod[1] = bus_wdata[7:2]; m_rl[1] = bus_wdata[0]; m_isrc = bus_wdata[1]; end
          default: ;
        endcase
      end
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = n_cnt[i]; m_left[i] = n_left[i]; m_en[i] = n_en[i];
        m_tog[i] = m_tog[i] ^ tc[i];
      end
      m_div = (m_div + 1) % 4;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = tin;
    end
  end

  function automatic int model_rd(int a);
    case (a)
      0: return (m_out << 6) | (m_in << 4) | (m_en[1] << 3) | (m_en[0] << 1);
      1: return m_cnt[0];
      2: return m_cnt[1];
      3, 4: return 255;
      default: return 0;
    endcase
  endfunction

  function automatic int model_tout();
    case (m_out)
      1: return m_tog[0];
      2: return m_tog[1];
      3: return (m_div >= 2) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && run_cmp) begin
      chk({cur_req, " rdata"}, int'(bus_rdata), model_rd(int'(bus_addr)));
      chk({cur_req, " tout"}, int'(tout), model_tout());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic watch(input logic [2:0] a);
    @(negedge clk);
    bus_addr = a;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input string req, input logic [2:0] a, input int exp);
    @(negedge clk);
    bus_addr = a;
    #5;
    chk(req, int'(bus_rdata), exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R13 prescaler reads
    peek("R1", 3'd0, 0);
    peek("R1", 3'd1, 0);
    peek("R1", 3'd2, 0);
    #1 chk("R1 tout", int'(tout), 0);
    peek("R13", 3'd3, 255);
    peek("R13", 3'd4, 255);
    run_cmp = 1'b1;

    // R3 R7 R8: timer 0 modulo, divisor 2, reload 5, output shows timer 0
    cur_req = "R3/R7/R8";
    wr(3'd3, 8'h09);
    wr(3'd1, 8'd5);
    wr(3'd0, 8'h43);
    watch(3'd1);
    wait_cyc(200);
    peek("R2", 3'd0, 8'h42);

    // R3 R6: divisor 0 means 64 ticks, single pass of 2 steps
    cur_req = "R3/R6";
    wr(3'd3, 8'h00);
    wr(3'd1, 8'd2);
    wr(3'd0, 8'h03);
    watch(3'd1);
    wait_cyc(300);
    peek("R3", 3'd1, 1);
    wait_cyc(300);
    peek("R6", 3'd1, 0);
    peek("R6", 3'd0, 0);

    // R5: reload value 0 runs 256 steps
    cur_req = "R5";
    wr(3'd3, 8'h04);
    wr(3'd1, 8'd0);
    wr(3'd0, 8'h03);
    watch(3'd1);
    wait_cyc(1000);
    #5 chk("R5 still running", int'(bus_rdata != 0), 1);
    wait_cyc(40);
    #5 chk("R5 done", int'(bus_rdata), 0);

    // R5: clearing enable halts the count
    wr(3'd1, 8'd50);
    wr(3'd0, 8'h03);
    watch(3'd1);
    wait_cyc(20);
    wr(3'd0, 8'h00);
    watch(3'd1);
    begin
      int held;
      #5 held = int'(bus_rdata);
      wait_cyc(30);
      #5 chk("R5 halt", int'(bus_rdata), held);
    end

    // R4 R8: internal clock on the pin
    cur_req = "R4/R8";
    wr(3'd0, 8'hC0);
    wait_cyc(24);

    // R9: timer 1 on external rising edges, divisor 1, modulo
    cur_req = "R9";
    wr(3'd4, 8'h05);
    wr(3'd2, 8'd3);
    wr(3'd0, 8'h8C);
    watch(3'd2);
    for (int k = 0; k < 24; k++) begin
      tin = ~tin;
      wait_cyc(3);
    end
    tin = 1'b0;
    wait_cyc(6);

    // R10: gate mode, internal source
    cur_req = "R10";
    wr(3'd4, 8'h07);
    wr(3'd2, 8'd10);
    tin = 1'b1;
    wr(3'd0, 8'h9C);
    watch(3'd2);
    wait_cyc(40);
    tin = 1'b0;
    wait_cyc(40);
    tin = 1'b1;
    wait_cyc(40);

    // R11: non-retriggerable trigger, single pass
    cur_req = "R11";
    wr(3'd4, 8'h06);
    wr(3'd2, 8'd20);
    wr(3'd0, 8'hA0);
    watch(3'd2);
    wait_cyc(10);
    tin = 1'b0;
    wait_cyc(20);
    tin = 1'b1;
    wait_cyc(10);
    tin = 1'b0;
    wait_cyc(100);
    peek("R11 run over", 3'd2, 0);
    tin = 1'b1;
    wait_cyc(10);
    tin = 1'b0;
    wait_cyc(30);

    // R12: retriggerable, edges every 30 clocks keep it from ending
    cur_req = "R12";
    wr(3'd4, 8'h07);
    wr(3'd2, 8'd20);
    tin = 1'b1;
    wr(3'd0, 8'hB0);
    watch(3'd2);
    for (int k = 0; k < 5; k++) begin
      wait_cyc(15);
      tin = 1'b0;
      wait_cyc(15);
      tin = 1'b1;
    end
    wait_cyc(200);

    run_cmp = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule